// File: doc/BRIEF.md
# Dual-Field Word-Serial Montgomery Processing Unit

This block is one slice of a word-serial, bit-scanned Montgomery multiplier. It serves either prime fields, with integer arithmetic, or binary extension fields, with carry-free polynomial arithmetic. Each time the caller steps it, it takes one bit of the multiplier, one W-bit word of the multiplicand and one of the modulus, and the matching word of the running partial result. The partial result is kept as a pair of words, a sum word and a carry word. The unit adds the gated multiplicand word in a first row of dual-mode adder cells. It adds the gated modulus word in a second row. It then halves the result by a one-bit right shift whose top bit comes from the next word up. The result stays in carry-save form and is never resolved to a single binary word.

A caller makes one pass over all words for each multiplier bit, least significant word first. The first word of a pass computes the reduction bit, which is then held for the rest of the pass. A pass ends with a last-word marker. One cycle later, the unit flushes the top aligned word by itself. The aligned words that come out of one pass are fed back as the partial result of the next pass. After one pass for each multiplier bit, the pair of words holds the Montgomery product.

Top module: `mwd_mont_pu`

## Requirements
- R1: After reset, `out_vld` is low and `out_ts` and `out_tc` are all zero.
- R2: With `fsel`=0 (prime field) and an odd modulus, one pass over the words turns a carry-save value S into S' = (S + a·B + q·M)/2 in the sum of the output words. Here q is the low bit of S + a·B, which makes the division exact.
- R3: With `fsel`=1 (binary field, modulus polynomial with a constant term), one pass gives S' = (S xor a·B xor q·M) >> 1 in the XOR of the output words. Here q is bit 0 of S xor a·B, and every output carry word is zero.
- R4: A pass with `a_bit`=0 adds no multiplicand: S' = (S + q·M)/2, or its carry-free form in the binary field.
- R5: The reduction bit is formed only on the word marked `in_first`, from bit 0 of that word's sum, carry and gated multiplicand. The same bit is then used for every higher word of the pass.
- R6: Aligned output word j-1 appears (`out_vld` high) in the cycle after word j is accepted. Word N-1 appears two cycles after the last word, with its top bit zero. A pass of N words yields exactly N valid words, and none appear between passes.
- R7: In the prime field, after n passes driven by the n bits of a, with the partial result starting at zero and B < M < 2^(W·N-2), the sum of the carry-save pair is below 2M and is congruent to a·B·2^(-n) mod M.
- R8: In the binary field, under the same pass sequence, the XOR of the pair times x^n reduced by M(x) equals a(x)·B(x) reduced by M(x).
- R9: `fsel` may change between multiplications without a reset, and the next multiplication follows the new mode from its first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsel | input | 1 | Field select: 0 prime (with carries), 1 binary (carry-free) |
| in_vld | input | 1 | A word is presented this cycle |
| in_first | input | 1 | Presented word is word 0 of a pass |
| in_last | input | 1 | Presented word is the top word of a pass |
| a_bit | input | 1 | Multiplier bit scanned in this pass |
| b_word | input | W | Multiplicand word j |
| m_word | input | W | Modulus word j |
| ts_word | input | W | Partial-result sum word j |
| tc_word | input | W | Partial-result carry word j |
| out_vld | output | 1 | Aligned output word valid |
| out_ts | output | W | Aligned sum word of the new partial result |
| out_tc | output | W | Aligned carry word of the new partial result |

## Verification
The bench chains whole multiplications through the unit. It feeds each pass's aligned words back in, so any misplaced bit soon spoils the product. The operands that fill every bit and sit near the modulus limit exercise the carries that leave the top of every word. A unit that dropped those inter-word carries, or did not clear them on a first word, would give a per-pass sum off by a power of two. A reduction bit taken from the current word instead of word 0 would leave an odd value, so the halving would be inexact. A shift that took its top bit from the wrong neighbour, or lost the flushed top word, would break both the per-pass sum and the word count. In the binary field, any leaked carry shows up as a nonzero carry word. Multiplier bits of zero and a switch of field between runs show whether a·B gating and mode selection are correct.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

   typedef enum logic {
      FIELD_PRIME  = 1'b0,
      FIELD_BINARY = 1'b1
   } field_e;

   // carry of one dual-mode cell: majority in the prime field, none in the binary field
   function automatic logic cell_carry(field_e f, logic x, logic y, logic z);
      return (f == FIELD_BINARY) ? 1'b0 : ((x & y) | (x & z) | (y & z));
   endfunction

endpackage

// File: rtl/mwd_csa_row.sv
module mwd_csa_row
   import mwd_pkg::*;
#(
   parameter int W = 8
) (
   input  field_e         fld,
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   input  logic [W-1:0]   z,
   input  logic           cin,
   output logic [W-1:0]   s,
   output logic [W-1:0]   cvec,
   output logic           cout
);

   localparam int TOP = W - 1;

   logic [W-1:0] cy;
   logic         cin_g;

   if (W < 2) begin : g_bad_width
      $error("mwd_csa_row: W must be at least 2");
   end

   assign cin_g = (fld == FIELD_BINARY) ? 1'b0 : cin;

   for (genvar k = 0; k < W; k++) begin : g_cell
      assign s[k]  = x[k] ^ y[k] ^ z[k];
      assign cy[k] = cell_carry(fld, x[k], y[k], z[k]);
   end

   // carry vector realigned one place up; the lowest slot takes the word-below carry
   assign cvec = {cy[TOP-1:0], cin_g};
   assign cout = cy[TOP];

endmodule

// File: rtl/mwd_align.sv
module mwd_align #(
   parameter int W = 8
) (
   input  logic           flush,
   input  logic           s_lsb,
   input  logic           c_lsb,
   input  logic [W-2:0]   hold_s,
   input  logic [W-2:0]   hold_c,
   output logic [W-1:0]   ts_o,
   output logic [W-1:0]   tc_o
);

   localparam int HB = W - 1;

   logic top_s, top_c;

   // above the top word there is nothing left, so the flushed word gets a zero top bit
   assign top_s = flush ? 1'b0 : s_lsb;
   assign top_c = flush ? 1'b0 : c_lsb;

   assign ts_o = {top_s, hold_s[HB-1:0]};
   assign tc_o = {top_c, hold_c[HB-1:0]};

endmodule

// File: rtl/mwd_mont_pu.sv
module mwd_mont_pu
   import mwd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fsel,
   input  logic           in_vld,
   input  logic           in_first,
   input  logic           in_last,
   input  logic           a_bit,
   input  logic [W-1:0]   b_word,
   input  logic [W-1:0]   m_word,
   input  logic [W-1:0]   ts_word,
   input  logic [W-1:0]   tc_word,
   output logic           out_vld,
   output logic [W-1:0]   out_ts,
   output logic [W-1:0]   out_tc
);

   localparam int HW = W - 1;

   if (W < 2) begin : g_bad_width
      $error("mwd_mont_pu: W must be at least 2");
   end

   field_e fld;
   assign fld = field_e'(fsel);

   // held state across the words of one pass
   logic          q_r;
   logic          c1_r, c2_r;
   logic          flush_r;
   logic [HW-1:0] hold_s, hold_c;
   logic          out_vld_r;
   logic [W-1:0]  out_ts_r, out_tc_r;

   // reduction bit: fresh on word 0, held for the higher words
   logic q_fresh, q_now;
   assign q_fresh = ts_word[0] ^ tc_word[0] ^ (a_bit & b_word[0]);
   assign q_now   = in_first ? q_fresh : q_r;

   logic [W-1:0] b_gated, m_gated;
   assign b_gated = {W{a_bit}} & b_word;
   assign m_gated = {W{q_now}} & m_word;

   logic c1_in, c2_in;
   assign c1_in = in_first ? 1'b0 : c1_r;
   assign c2_in = in_first ? 1'b0 : c2_r;

   // layer 1: partial result plus gated multiplicand
   logic [W-1:0] s1, c1v;
   logic         c1_top;
   mwd_csa_row #(.W(W)) u_layer_b (
      .fld  (fld),
      .x    (ts_word),
      .y    (tc_word),
      .z    (b_gated),
      .cin  (c1_in),
      .s    (s1),
      .cvec (c1v),
      .cout (c1_top)
   );

   // layer 2: plus gated modulus
   logic [W-1:0] s2, c2v;
   logic         c2_top;
   mwd_csa_row #(.W(W)) u_layer_m (
      .fld  (fld),
      .x    (s1),
      .y    (c1v),
      .z    (m_gated),
      .cin  (c2_in),
      .s    (s2),
      .cvec (c2v),
      .cout (c2_top)
   );

   // shift right by one, top bit borrowed from the current (next higher) word
   logic [W-1:0] al_ts, al_tc;
   mwd_align #(.W(W)) u_align (
      .flush  (flush_r),
      .s_lsb  (s2[0]),
      .c_lsb  (c2v[0]),
      .hold_s (hold_s),
      .hold_c (hold_c),
      .ts_o   (al_ts),
      .tc_o   (al_tc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r       <= 1'b0;
         c1_r      <= 1'b0;
         c2_r      <= 1'b0;
         flush_r   <= 1'b0;
         hold_s    <= '0;
         hold_c    <= '0;
         out_vld_r <= 1'b0;
         out_ts_r  <= '0;
         out_tc_r  <= '0;
      end else begin
         out_vld_r <= flush_r | (in_vld & ~in_first);
         if (flush_r | (in_vld & ~in_first)) begin
            out_ts_r <= al_ts;
            out_tc_r <= al_tc;
         end
         if (in_vld) begin
            if (in_first) q_r <= q_fresh;
            c1_r    <= c1_top;
            c2_r    <= c2_top;
            hold_s  <= s2[W-1:1];
            hold_c  <= c2v[W-1:1];
            flush_r <= in_last;
         end else begin
            flush_r <= 1'b0;
         end
      end
   end

   assign out_vld = out_vld_r;
   assign out_ts  = out_ts_r;
   assign out_tc  = out_tc_r;

   // ---------------- assertions ----------------
   // R2/R3/R5: with an odd modulus the held reduction bit clears bit 0 of word 0
   p_lsb_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_first && m_word[0]) |-> (s2[0] == 1'b0 && c2v[0] == 1'b0));

   // R3: the binary field produces no carry anywhere in either layer
   p_no_carry_gf2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && fsel) |-> (c1v == '0 && c2v == '0 && !c1_top && !c2_top));

   // R3: an aligned word produced in the binary field carries an all-zero carry word
   p_tc_zero_gf2_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !in_first && fsel && !flush_r) |=> (out_vld && out_tc == '0));

   // R6: every non-first word emits the aligned word below it one cycle later
   p_word_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !in_first) |=> out_vld);

   // R6: the top word is flushed two cycles after the last word
   p_flush_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_last) |-> ##2 out_vld);

   // R6: a flush cycle is never shared with a non-first word
   p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_r |-> !(in_vld && !in_first));

endmodule

// File: tb/sim_mwd_mont_pu.sv
module sim_mwd_mont_pu;

   localparam int W   = 8;
   localparam int NW  = 4;
   localparam int TOT = W * NW;

   typedef struct {
      longint unsigned val;
      logic            gf2;
      logic            abit;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           fsel = 1'b0;
   logic           in_vld = 1'b0;
   logic           in_first = 1'b0;
   logic           in_last = 1'b0;
   logic           a_bit = 1'b0;
   logic [W-1:0]   b_word = '0;
   logic [W-1:0]   m_word = '0;
   logic [W-1:0]   ts_word = '0;
   logic [W-1:0]   tc_word = '0;
   logic           out_vld;
   logic [W-1:0]   out_ts, out_tc;

   mwd_mont_pu #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .fsel(fsel), .in_vld(in_vld),
      .in_first(in_first), .in_last(in_last), .a_bit(a_bit),
      .b_word(b_word), .m_word(m_word), .ts_word(ts_word), .tc_word(tc_word),
      .out_vld(out_vld), .out_ts(out_ts), .out_tc(out_tc)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   exp_t          sb[$];
   logic [TOT-1:0] cs_ts = '0, cs_tc = '0;
   logic [TOT-1:0] acc_ts = '0, acc_tc = '0;
   int            wc = 0;
   int            done_cnt = 0;

   task automatic chk(input bit ok, input string req, input longint unsigned act,
                      input longint unsigned exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: collects aligned words and pops the scoreboard once a pass completes
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         acc_ts[wc*W +: W] = out_ts;
         acc_tc[wc*W +: W] = out_tc;
         wc++;
         if (wc == NW) begin
            exp_t e;
            wc = 0;
            if (sb.size() == 0) begin
               chk(1'b0, "R6 unexpected pass", 64'(acc_ts), 0);
            end else begin
               e = sb.pop_front();
               if (e.gf2) begin
                  chk((64'(acc_ts) ^ 64'(acc_tc)) == e.val,
                      e.abit ? "R3 R5 binary pass" : "R3 R4 binary pass a_bit=0",
                      64'(acc_ts) ^ 64'(acc_tc), e.val);
                  chk(acc_tc == '0, "R3 carry word zero", 64'(acc_tc), 0);
               end else begin
                  chk((64'(acc_ts) + 64'(acc_tc)) == e.val,
                      e.abit ? "R2 R5 prime pass" : "R2 R4 prime pass a_bit=0",
                      64'(acc_ts) + 64'(acc_tc), e.val);
               end
            end
            cs_ts = acc_ts;
            cs_tc = acc_tc;
            done_cnt++;
         end
      end
   end

   function automatic int pdeg(input longint unsigned v);
      int d = -1;
      for (int k = 0; k < 64; k++) if (v[k]) d = k;
      return d;
   endfunction

   function automatic longint unsigned pmod(input longint unsigned v, input longint unsigned m);
      longint unsigned r = v;
      int dm = pdeg(m);
      for (int k = 63; k >= dm; k--) if (r[k]) r = r ^ (m << (k - dm));
      return r;
   endfunction

   function automatic longint unsigned pmul(input longint unsigned a, input longint unsigned b);
      longint unsigned r = 0;
      for (int k = 0; k < 32; k++) if (a[k]) r = r ^ (b << k);
      return r;
   endfunction

   // one full multiplication: n passes, each NW words then a flush
   task automatic run_mult(input bit gf2, input longint unsigned m, input longint unsigned a,
                           input longint unsigned b, input int n, input string tag);
      longint unsigned r = 0;
      longint unsigned fin, lhs, rhs;
      cs_ts = '0;
      cs_tc = '0;
      for (int i = 0; i < n; i++) begin
         exp_t e;
         longint unsigned ab = a[i] ? b : 64'd0;
         logic q;
         int target;
         if (gf2) begin
            q = (r ^ ab) & 1;
            r = (r ^ ab ^ (q ? m : 64'd0)) >> 1;
         end else begin
            q = (r + ab) & 1;
            r = (r + ab + (q ? m : 64'd0)) >> 1;
         end
         e.val = r; e.gf2 = gf2; e.abit = a[i];
         sb.push_back(e);
         target = done_cnt + 1;
         for (int j = 0; j < NW; j++) begin
            @(negedge clk);
            if (j >= 1) chk(out_vld == (j >= 2), "R6 emit timing", 64'(out_vld), 64'(j >= 2));
            fsel     = gf2;
            in_vld   = 1'b1;
            in_first = (j == 0);
            in_last  = (j == NW - 1);
            a_bit    = a[i];
            b_word   = b[j*W +: W];
            m_word   = m[j*W +: W];
            ts_word  = cs_ts[j*W +: W];
            tc_word  = cs_tc[j*W +: W];
         end
         @(negedge clk);
         in_vld = 1'b0; in_first = 1'b0; in_last = 1'b0;
         wait (done_cnt == target);
         @(negedge clk);
         chk(out_vld == 1'b0, "R6 no extra word", 64'(out_vld), 0);
      end
      if (gf2) begin
         fin = 64'(cs_ts) ^ 64'(cs_tc);
         lhs = fin;
         for (int k = 0; k < n; k++) lhs = pmod(lhs << 1, m);
         rhs = pmod(pmul(a, b), m);
         chk(lhs == rhs, {"R8 binary product ", tag}, lhs, rhs);
      end else begin
         fin = 64'(cs_ts) + 64'(cs_tc);
         chk(fin < 2 * m, {"R7 prime range ", tag}, fin, 2 * m);
         lhs = fin % m;
         for (int k = 0; k < n; k++) lhs = (lhs * 2) % m;
         rhs = (a * b) % m;
         chk(lhs == rhs, {"R7 prime product ", tag}, lhs, rhs);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_vld == 1'b0, "R1 reset valid", 64'(out_vld), 0);
      chk(out_ts == '0 && out_tc == '0, "R1 reset words", 64'({out_ts, out_tc}), 0);

      run_mult(1'b0, 64'h2F3A51C7, 64'h12345678, 64'h0ABCDEF1, 30, "typical");
      run_mult(1'b0, 64'h3FFFFFFD, 64'h3FFFFFFF, 64'h3FFFFFFC, 30, "all ones near limit");
      run_mult(1'b0, 64'h2F3A51C7, 64'h20000001, 64'h2F3A51C6, 30, "sparse multiplier R4");
      run_mult(1'b1, 64'h20000053, 64'h1555AAAA, 64'h0F0F1234, 30, "typical");
      run_mult(1'b1, 64'h20000005, 64'h3FFFFFFF, 64'h1FFFFFFF, 30, "dense");
      // R9: back to the prime field right after a binary run, no reset in between
      run_mult(1'b0, 64'h000000F1, 64'h3A5A5A5B, 64'h000000A5, 30, "R9 mode switch");
      run_mult(1'b1, 64'h00000083, 64'h2AAAAAAA, 64'h0000007F, 30, "R9 mode switch");

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule